// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits in front of one processor and decides which single interrupt is offered to it at a time. Source units deliver requests that carry a source number, a priority and the id of the sending unit. The block compares each request with the processor's current priority ceiling and with whatever is already pending. It keeps the better of the two and returns the loser to its unit as a reject. A second path lets software post an inter-processor request through a priority register. That request competes in the same arbitration and uses a reserved source number that no unit owns.

Software sees a 32-bit presentation word, with the ceiling in the top byte and the pending source number in the low 24 bits. Reading it through the accept strobe claims the pending interrupt. The processor can then write a new ceiling, write the inter-processor priority, or write an end-of-interrupt word. That word restores the ceiling and tells the source units which number has finished. Numerically lower priorities win, and 0xFF is the least favoured value. The processor interrupt line is high whenever a source number is pending.

Top module: `ipres_top`

## Requirements
- R1: After reset the presentation word reads 0x00000000, the interrupt line is low, and the reject and end-of-interrupt outputs are idle. The inter-processor priority and the hidden pending priority both start at 0xFF.
- R2: The presentation word `acc_data` holds the ceiling in bits 31:24 and the pending source in bits 23:0. `irq_out` is high exactly when bits 23:0 are nonzero.
- R3: A delivery is refused, and the word is left unchanged, when its priority is greater than or equal to the ceiling. It is also refused when a source is pending whose priority is less than or equal to the new one. In the cycle after a refusal, `rej_valid` pulses and carries the delivered source number and unit id.
- R4: A delivery that is not refused replaces the pending source, its priority and its owning unit, and raises the line in the next cycle. If the displaced source was owned by a unit, it is rejected to that unit in the same cycle.
- R5: `acc_data` shows the current word while `acc_rd` is high. In the next cycle the ceiling equals the old pending priority, the source field is 0, the line is low, and the pending priority becomes 0xFF.
- R6: A ceiling write updates the ceiling. If the new ceiling is lower than the old one, a source is pending, and the new ceiling is less than or equal to the pending priority, then the pending source is dropped and the line is lowered. The pending priority becomes 0xFF, and an owned source is rejected to its unit.
- R7: An end-of-interrupt write loads the ceiling from bits 31:24 of the written word. It pulses `eoi_valid` in the next cycle with bits 23:0, unless those bits are 0 or the reserved inter-processor number 2. Source units decode the number themselves.
- R8: An inter-processor priority write that is lower than the ceiling presents source number 2 at that priority, with no owner. This happens unless a source is already pending at a priority less than or equal to the written value. Any owned source displaced this way is rejected.
- R9: The inter-processor check is repeated after an end-of-interrupt write, using the new ceiling. It is also repeated after a ceiling write that leaves nothing pending.
- R10: Only one operation acts per cycle. The order of precedence is accept, end-of-interrupt, ceiling write, inter-processor write, then delivery. `dlv_ack` is high only when a delivery is the acting operation, and a delivery without `dlv_ack` has no effect.
- R11: `rej_valid` and `eoi_valid` are single-cycle pulses, registered one cycle after the operation that causes them, and low in any cycle that follows an operation which causes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dlv_valid | input | 1 | Delivery request from a source unit |
| dlv_src | input | 24 | Delivered source number |
| dlv_prio | input | 8 | Delivered priority |
| dlv_unit | input | 2 | Id of the delivering unit |
| dlv_ack | output | 1 | Delivery acted on this cycle |
| acc_rd | input | 1 | Accept strobe |
| acc_data | output | 32 | Presentation word (ceiling, source) |
| cppr_we | input | 1 | Ceiling write strobe |
| cppr_wdata | input | 8 | New ceiling |
| mfrr_we | input | 1 | Inter-processor priority write strobe |
| mfrr_wdata | input | 8 | New inter-processor priority |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| eoi_wdata | input | 32 | End-of-interrupt word |
| rej_valid | output | 1 | Reject pulse to source units |
| rej_src | output | 24 | Rejected source number |
| rej_unit | output | 2 | Unit that owns the rejected source |
| eoi_valid | output | 1 | End-of-interrupt pulse to source units |
| eoi_src | output | 24 | Finished source number |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
A wrong pending priority, owner or ceiling does not show up at once. It appears one operation later: a delivery that should be refused is taken, a reject goes to the wrong unit or is missing, or an accept loads the wrong ceiling. The bench therefore chains a preparation phase, first and second deliveries, ceilings and inter-processor writes across dense priority grids. It compares the word, the line and both notification buses after every operation, so a corrupted field is reported within one or two cycles of the operation that reveals it.

// File: rtl/ipres_pkg.sv
// Shared types for the interrupt presentation controller.
// Assumes one operation acts per cycle, selected by fixed precedence.
package ipres_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ACCEPT,
        OP_EOI,
        OP_CEIL,
        OP_IPI,
        OP_DLV
    } ipres_op_e;

endpackage

// File: rtl/ipres_opsel.sv
// Picks the single operation that acts this cycle.
// Precedence: accept, end-of-interrupt, ceiling, inter-processor, delivery.
module ipres_opsel
    import ipres_pkg::*;
(
    input  logic      acc_rd,
    input  logic      eoi_we,
    input  logic      cppr_we,
    input  logic      mfrr_we,
    input  logic      dlv_valid,
    output ipres_op_e op
);

    // Fixed-priority decode of the request strobes
    always_comb begin
        if (acc_rd)         op = OP_ACCEPT;
        else if (eoi_we)    op = OP_EOI;
        else if (cppr_we)   op = OP_CEIL;
        else if (mfrr_we)   op = OP_IPI;
        else if (dlv_valid) op = OP_DLV;
        else                op = OP_IDLE;
    end

endmodule

// File: rtl/ipres_cmp.sv
// Decides whether a candidate priority may be presented.
// Assumes lower value is more favoured; the candidate must beat the ceiling
// and must be strictly better than any pending priority.
module ipres_cmp #(
    parameter int unsigned PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand,
    input  logic [PRIO_W-1:0] ceiling,
    input  logic              busy,
    input  logic [PRIO_W-1:0] pend,
    output logic              take
);

    // Candidate wins over the ceiling and over the pending interrupt
    always_comb take = (cand < ceiling) && !(busy && (pend <= cand));

endmodule

// File: rtl/ipres_notify.sv
// Registered single-cycle notification toward the source units.
// Assumes at most one notification per cycle on each instance.
module ipres_notify #(
    parameter int unsigned W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] data,
    output logic         valid_q,
    output logic [W-1:0] data_q
);

    // Capture a pulse and its payload for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= fire;
            data_q  <= fire ? data : '0;
        end
    end

endmodule

// File: rtl/ipres_top.sv
// Per-processor interrupt presenter: arbitrates deliveries and the
// inter-processor request against the ceiling, returns losers as rejects,
// and forwards end-of-interrupt numbers. Assumes a delivering unit holds its
// request until dlv_ack, and that units decode finished numbers themselves.
module ipres_top
    import ipres_pkg::*;
#(
    parameter int unsigned SRC_W   = 24,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned UNIT_W  = 2,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dlv_valid,
    input  logic [SRC_W-1:0]          dlv_src,
    input  logic [PRIO_W-1:0]         dlv_prio,
    input  logic [UNIT_W-1:0]         dlv_unit,
    output logic                      dlv_ack,
    input  logic                      acc_rd,
    output logic [SRC_W+PRIO_W-1:0]   acc_data,
    input  logic                      cppr_we,
    input  logic [PRIO_W-1:0]         cppr_wdata,
    input  logic                      mfrr_we,
    input  logic [PRIO_W-1:0]         mfrr_wdata,
    input  logic                      eoi_we,
    input  logic [SRC_W+PRIO_W-1:0]   eoi_wdata,
    output logic                      rej_valid,
    output logic [SRC_W-1:0]          rej_src,
    output logic [UNIT_W-1:0]         rej_unit,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      irq_out
);

    localparam int unsigned REG_W  = SRC_W + PRIO_W;
    localparam int unsigned NOTE_W = SRC_W + UNIT_W;
    localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM    = SRC_W'(IPI_SRC);

    logic [PRIO_W-1:0] ceil_q, pend_q, ipi_q;
    logic [SRC_W-1:0]  src_q;
    logic [UNIT_W-1:0] owner_q;
    logic              owned_q, line_q;

    logic [PRIO_W-1:0] ceil_n, pend_n, ipi_n;
    logic [SRC_W-1:0]  src_n;
    logic [UNIT_W-1:0] owner_n;
    logic              owned_n, line_n;

    logic              rej_fire, fin_fire, ipi_check;
    logic [NOTE_W-1:0] rej_bus;
    logic [SRC_W-1:0]  fin_num;
    logic [PRIO_W-1:0] ceil_eff, ipi_cand;
    logic              dlv_take, ipi_take, src_busy;
    ipres_op_e         op;

    ipres_opsel u_opsel (
        .acc_rd    (acc_rd),
        .eoi_we    (eoi_we),
        .cppr_we   (cppr_we),
        .mfrr_we   (mfrr_we),
        .dlv_valid (dlv_valid),
        .op        (op)
    );

    assign src_busy = |src_q;
    assign dlv_ack  = (op == OP_DLV);
    assign acc_data = {ceil_q, src_q};
    assign irq_out  = line_q;

    // Ceiling and candidate the inter-processor check compares against
    always_comb begin
        ceil_eff = ceil_q;
        ipi_cand = ipi_q;
        if (op == OP_EOI)  ceil_eff = eoi_wdata[REG_W-1:SRC_W];
        if (op == OP_CEIL) ceil_eff = cppr_wdata;
        if (op == OP_IPI)  ipi_cand = mfrr_wdata;
    end

    ipres_cmp #(.PRIO_W(PRIO_W)) u_dlv_cmp (
        .cand    (dlv_prio),
        .ceiling (ceil_q),
        .busy    (src_busy),
        .pend    (pend_q),
        .take    (dlv_take)
    );

    ipres_cmp #(.PRIO_W(PRIO_W)) u_ipi_cmp (
        .cand    (ipi_cand),
        .ceiling (ceil_eff),
        .busy    (src_busy),
        .pend    (pend_q),
        .take    (ipi_take)
    );

    // Next-state and notification selection for the acting operation
    always_comb begin
        ceil_n    = ceil_q;
        pend_n    = pend_q;
        ipi_n     = ipi_q;
        src_n     = src_q;
        owner_n   = owner_q;
        owned_n   = owned_q;
        line_n    = line_q;
        rej_fire  = 1'b0;
        rej_bus   = '0;
        fin_fire  = 1'b0;
        fin_num   = '0;
        ipi_check = 1'b0;
        case (op)
            OP_ACCEPT: begin
                ceil_n  = pend_q;
                src_n   = '0;
                pend_n  = PRIO_LEAST;
                owned_n = 1'b0;
                line_n  = 1'b0;
            end
            OP_EOI: begin
                ceil_n    = eoi_wdata[REG_W-1:SRC_W];
                fin_num   = eoi_wdata[SRC_W-1:0];
                fin_fire  = (fin_num != '0) && (fin_num != IPI_NUM);
                ipi_check = 1'b1;
            end
            OP_CEIL: begin
                ceil_n = cppr_wdata;
                if ((cppr_wdata < ceil_q) && src_busy && (cppr_wdata <= pend_q)) begin
                    rej_fire = owned_q;
                    rej_bus  = {owner_q, src_q};
                    src_n    = '0;
                    pend_n   = PRIO_LEAST;
                    owned_n  = 1'b0;
                    line_n   = 1'b0;
                end else begin
                    ipi_check = !src_busy;
                end
            end
            OP_IPI: begin
                ipi_n     = mfrr_wdata;
                ipi_check = 1'b1;
            end
            OP_DLV: begin
                if (dlv_take) begin
                    rej_fire = src_busy && owned_q;
                    rej_bus  = {owner_q, src_q};
                    src_n    = dlv_src;
                    pend_n   = dlv_prio;
                    owner_n  = dlv_unit;
                    owned_n  = 1'b1;
                    line_n   = 1'b1;
                end else begin
                    rej_fire = 1'b1;
                    rej_bus  = {dlv_unit, dlv_src};
                end
            end
            default: ;
        endcase
        if (ipi_check && ipi_take) begin
            rej_fire = src_busy && owned_q;
            rej_bus  = {owner_q, src_q};
            src_n    = IPI_NUM;
            pend_n   = ipi_cand;
            owned_n  = 1'b0;
            line_n   = 1'b1;
        end
    end

    // Presentation state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceil_q  <= '0;
            pend_q  <= PRIO_LEAST;
            ipi_q   <= PRIO_LEAST;
            src_q   <= '0;
            owner_q <= '0;
            owned_q <= 1'b0;
            line_q  <= 1'b0;
        end else begin
            ceil_q  <= ceil_n;
            pend_q  <= pend_n;
            ipi_q   <= ipi_n;
            src_q   <= src_n;
            owner_q <= owner_n;
            owned_q <= owned_n;
            line_q  <= line_n;
        end
    end

    logic [NOTE_W-1:0] rej_out;

    ipres_notify #(.W(NOTE_W)) u_rej_note (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (rej_fire),
        .data    (rej_bus),
        .valid_q (rej_valid),
        .data_q  (rej_out)
    );

    assign rej_unit = rej_out[NOTE_W-1:SRC_W];
    assign rej_src  = rej_out[SRC_W-1:0];

    ipres_notify #(.W(SRC_W)) u_fin_note (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fin_fire),
        .data    (fin_num),
        .valid_q (eoi_valid),
        .data_q  (eoi_src)
    );

endmodule

// File: rtl/ipres_chk.sv
// Port-level properties of the presentation controller, bound to the top.
// Assumes the same parameter values as the bound instance.
module ipres_chk #(
    parameter int unsigned SRC_W   = 24,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned UNIT_W  = 2,
    parameter int unsigned IPI_SRC = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dlv_valid,
    input logic [SRC_W-1:0]        dlv_src,
    input logic [PRIO_W-1:0]       dlv_prio,
    input logic [UNIT_W-1:0]       dlv_unit,
    input logic                    dlv_ack,
    input logic                    acc_rd,
    input logic [SRC_W+PRIO_W-1:0] acc_data,
    input logic                    cppr_we,
    input logic                    mfrr_we,
    input logic [PRIO_W-1:0]       mfrr_wdata,
    input logic                    eoi_we,
    input logic [SRC_W+PRIO_W-1:0] eoi_wdata,
    input logic                    rej_valid,
    input logic [SRC_W-1:0]        rej_src,
    input logic [UNIT_W-1:0]       rej_unit,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src,
    input logic                    irq_out
);

    localparam int unsigned REG_W = SRC_W + PRIO_W;

    assert_line_follows_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (acc_data[SRC_W-1:0] != '0));

    assert_refused_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_ack && (dlv_prio >= acc_data[REG_W-1:SRC_W]))
        |=> (rej_valid && rej_src == $past(dlv_src) && rej_unit == $past(dlv_unit)));

    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> (acc_data[SRC_W-1:0] == '0 && !irq_out));

    assert_eoi_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_we && !acc_rd) |=> acc_data[REG_W-1:SRC_W] == $past(eoi_wdata[REG_W-1:SRC_W]));

    assert_eoi_number_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_src != '0 && eoi_src != SRC_W'(IPI_SRC)));

    assert_ipi_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mfrr_we && !acc_rd && !eoi_we && !cppr_we && acc_data[SRC_W-1:0] == '0
         && mfrr_wdata < acc_data[REG_W-1:SRC_W])
        |=> (acc_data[SRC_W-1:0] == SRC_W'(IPI_SRC) && irq_out));

    assert_no_ack_on_regop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd || eoi_we || cppr_we || mfrr_we) |-> !dlv_ack);

    assert_ack_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_ack |-> dlv_valid);

endmodule

bind ipres_top ipres_chk #(
    .SRC_W   (SRC_W),
    .PRIO_W  (PRIO_W),
    .UNIT_W  (UNIT_W),
    .IPI_SRC (IPI_SRC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dlv_valid  (dlv_valid),
    .dlv_src    (dlv_src),
    .dlv_prio   (dlv_prio),
    .dlv_unit   (dlv_unit),
    .dlv_ack    (dlv_ack),
    .acc_rd     (acc_rd),
    .acc_data   (acc_data),
    .cppr_we    (cppr_we),
    .mfrr_we    (mfrr_we),
    .mfrr_wdata (mfrr_wdata),
    .eoi_we     (eoi_we),
    .eoi_wdata  (eoi_wdata),
    .rej_valid  (rej_valid),
    .rej_src    (rej_src),
    .rej_unit   (rej_unit),
    .eoi_valid  (eoi_valid),
    .eoi_src    (eoi_src),
    .irq_out    (irq_out)
);

// File: tb/ipres_top_tb.sv
// Self-checking bench: sweeps priority grids and directed corner cases,
// predicting every output from the requirement rules.
module ipres_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_prio = '0;
    logic [1:0]  dlv_unit = '0;
    logic        dlv_ack;
    logic        acc_rd = 1'b0;
    logic [31:0] acc_data;
    logic        cppr_we = 1'b0;
    logic [7:0]  cppr_wdata = '0;
    logic        mfrr_we = 1'b0;
    logic [7:0]  mfrr_wdata = '0;
    logic        eoi_we = 1'b0;
    logic [31:0] eoi_wdata = '0;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic [1:0]  rej_unit;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        irq_out;

    always #5 clk = ~clk;

    ipres_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio), .dlv_unit(dlv_unit),
        .dlv_ack(dlv_ack), .acc_rd(acc_rd), .acc_data(acc_data),
        .cppr_we(cppr_we), .cppr_wdata(cppr_wdata), .mfrr_we(mfrr_we), .mfrr_wdata(mfrr_wdata),
        .eoi_we(eoi_we), .eoi_wdata(eoi_wdata),
        .rej_valid(rej_valid), .rej_src(rej_src), .rej_unit(rej_unit),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Expected state built from the requirements
    logic [7:0]  m_ceil, m_pend, m_ipi;
    logic [23:0] m_src;
    logic        m_owned;
    logic [1:0]  m_unit;
    logic        e_rv, e_ev;
    logic [23:0] e_rs, e_es;
    logic [1:0]  e_ru;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_reject(input logic [23:0] s, input logic [1:0] u);
        e_rv = 1'b1; e_rs = s; e_ru = u;
    endtask

    task automatic m_ipi_check(input logic [7:0] ceil);
        if (m_ipi < ceil && !(m_src != 0 && m_pend <= m_ipi)) begin
            if (m_src != 0 && m_owned) m_reject(m_src, m_unit);
            m_src = 24'd2; m_pend = m_ipi; m_owned = 1'b0;
        end
    endtask

    // Drives one cycle of strobes and compares the ports against the model
    task automatic op(input logic a, input logic e, input logic c, input logic m, input logic d,
                      input logic [31:0] ew, input logic [7:0] cw, input logic [7:0] mw,
                      input logic [7:0] dp, input logic [23:0] ds, input logic [1:0] du,
                      input string tag);
        logic exp_ack;
        acc_rd = a; eoi_we = e; cppr_we = c; mfrr_we = m; dlv_valid = d;
        eoi_wdata = ew; cppr_wdata = cw; mfrr_wdata = mw;
        dlv_prio = dp; dlv_src = ds; dlv_unit = du;
        #1;
        exp_ack = d && !(a || e || c || m);
        check({tag, " ack (R10)"}, 64'(dlv_ack), 64'(exp_ack));
        if (a) check({tag, " accept word (R5)"}, 64'(acc_data), 64'({m_ceil, m_src}));
        e_rv = 1'b0; e_rs = '0; e_ru = '0; e_ev = 1'b0; e_es = '0;
        if (a) begin
            m_ceil = m_pend; m_src = '0; m_pend = 8'hFF; m_owned = 1'b0;
        end else if (e) begin
            m_ceil = ew[31:24];
            if (ew[23:0] != 0 && ew[23:0] != 24'd2) begin e_ev = 1'b1; e_es = ew[23:0]; end
            m_ipi_check(m_ceil);
        end else if (c) begin
            if (cw < m_ceil && m_src != 0 && cw <= m_pend) begin
                if (m_owned) m_reject(m_src, m_unit);
                m_src = '0; m_pend = 8'hFF; m_owned = 1'b0; m_ceil = cw;
            end else begin
                m_ceil = cw;
                if (m_src == 0) m_ipi_check(m_ceil);
            end
        end else if (m) begin
            m_ipi = mw;
            m_ipi_check(m_ceil);
        end else if (d) begin
            if (dp >= m_ceil || (m_src != 0 && m_pend <= dp)) m_reject(ds, du);
            else begin
                if (m_src != 0 && m_owned) m_reject(m_src, m_unit);
                m_src = ds; m_pend = dp; m_owned = 1'b1; m_unit = du;
            end
        end
        @(posedge clk);
        #1;
        acc_rd = 0; eoi_we = 0; cppr_we = 0; mfrr_we = 0; dlv_valid = 0;
        @(negedge clk);
        check({tag, " word (R2)"}, 64'(acc_data), 64'({m_ceil, m_src}));
        check({tag, " line (R2)"}, 64'(irq_out), 64'(m_src != 0));
        check({tag, " reject bus (R11)"}, 64'({rej_valid, rej_unit, rej_src}),
              64'({e_rv, e_ru, e_rs}));
        check({tag, " eoi bus (R11)"}, 64'({eoi_valid, eoi_src}), 64'({e_ev, e_es}));
    endtask

    task automatic t_acc(input string tag);
        op(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic t_eoi(input logic [31:0] w, input string tag);
        op(0, 1, 0, 0, 0, w, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic t_ceil(input logic [7:0] w, input string tag);
        op(0, 0, 1, 0, 0, 0, w, 0, 0, 0, 0, tag);
    endtask
    task automatic t_ipi(input logic [7:0] w, input string tag);
        op(0, 0, 0, 1, 0, 0, 0, w, 0, 0, 0, tag);
    endtask
    task automatic t_dlv(input logic [7:0] p, input logic [23:0] s, input logic [1:0] u,
                         input string tag);
        op(0, 0, 0, 0, 1, 0, 0, 0, p, s, u, tag);
    endtask

    initial begin
        m_ceil = 0; m_pend = 8'hFF; m_ipi = 8'hFF; m_src = 0; m_owned = 0; m_unit = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset word", 64'(acc_data), 64'h0);
        check("R1 reset line and notes", 64'({irq_out, rej_valid, eoi_valid}), 64'h0);
        // Reset ceiling 0 refuses everything; reset MFRR 0xFF never presents
        t_dlv(8'h00, 24'h10, 2'd1, "R1 ceiling zero refuses");
        t_ceil(8'hFF, "R1 mfrr reset no ipi");
        t_acc("R1 pending priority reset");

        // Grid: ceiling vs first and second delivery priorities
        for (int c = 0; c < 6; c++)
            for (int p1 = 0; p1 < 8; p1++)
                for (int p2 = 0; p2 < 8; p2++) begin
                    t_acc("R5 prep");
                    t_eoi({8'(c * 3), 24'h0}, "R7 prep");
                    t_dlv(8'(p1 * 2), 24'(16 + p1), 2'(p1), "R3/R4 first");
                    t_dlv(8'(p2 * 2), 24'(32 + p2), 2'(p2 + 1), "R3/R4 second");
                end

        // Grid: ceiling write against a pending delivery
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 6; p++) begin
                t_acc("R5 prep");
                t_eoi({8'hFF, 24'h0}, "R7 prep");
                t_dlv(8'(p * 3), 24'(64 + p), 2'(c), "R4 pend");
                t_ceil(8'(c * 2), "R6 ceiling");
                t_idle_check();
            end

        // Grid: inter-processor priority vs ceiling, with and without pending
        for (int c = 0; c < 6; c++)
            for (int m = 0; m < 8; m++)
                for (int pd = 0; pd < 2; pd++) begin
                    t_acc("R5 prep");
                    t_eoi({8'(c * 3), 24'h0}, "R7 prep");
                    if (pd == 1) t_dlv(8'(m + 1), 24'h99, 2'd3, "R4 pend");
                    t_ipi(8'(m * 2), "R8 ipi write");
                    t_acc("R5 claim");
                    t_eoi({8'hFF, 24'h99}, "R9 eoi recheck");
                    t_ipi(8'hFF, "R8 ipi off");
                end

        // Directed: end-of-interrupt numbers 0, 2 and ordinary
        t_acc("R5 prep");
        t_eoi({8'h40, 24'd2}, "R7 reserved not forwarded");
        t_eoi({8'h50, 24'd0}, "R7 zero not forwarded");
        t_eoi({8'h60, 24'h123456}, "R7 forwarded");
        // IPI recheck after a ceiling write with nothing pending
        t_ipi(8'h70, "R8 above ceiling");
        t_ceil(8'h80, "R9 ceiling recheck");
        t_acc("R5 claim ipi");
        t_ipi(8'hFF, "R8 off");
        t_eoi({8'hFF, 24'd2}, "R7 ipi done");
        // Precedence: delivery alongside register ops is not acked
        op(0, 0, 1, 0, 1, 0, 8'h20, 0, 8'h01, 24'h77, 2'd2, "R10 ceiling beats delivery");
        op(1, 1, 0, 0, 0, {8'h90, 24'h55}, 0, 0, 0, 0, 0, "R10 accept beats eoi");
        op(0, 1, 0, 1, 0, {8'hA0, 24'h0}, 0, 8'h10, 0, 0, 0, "R10 eoi beats ipi");
        t_dlv(8'h05, 24'h44, 2'd1, "R4 take");
        t_dlv(8'h03, 24'h45, 2'd2, "R4 preempt");
        t_idle_check();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic t_idle_check();
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule